// File: doc/BRIEF.md
# Clear-to-Send Flow-Control Status Logic

This block sits between a serial port's clear-to-send input and both its transmit engine and its status register. The pin passes through a synchronizer. A programmable polarity is then applied to produce a live status bit, where 1 means the far end can accept data and 0 means it is busy. In loopback mode the pin is ignored, and the status follows the local manual request-to-send control bit instead.

The block produces a transmit-permit signal for the serializer. With automatic handshaking enabled, the permit follows the live status. With handshaking disabled, the permit follows a software pause bit. The permit is re-evaluated only at character boundaries, so a frame already being sent is never cut short.

Each rising edge of the live status sets a sticky flag. Software clears this flag by writing 1 to it. While its enable is set, the flag raises a line-status interrupt request.

Top module: `cts_flow_ctl`

## Requirements
- R1: `cts_status` equals the synchronized pin when `cts_pol_hi` is 1, and its inverse when `cts_pol_hi` is 0. A pin change reaches `cts_status` on the third rising clock edge, and a polarity change reaches it on the next edge.
- R2: While `loopback_en` is 1, `cts_status` takes the value of `rts_manual` on the next edge, and the pin has no effect on it.
- R3: `cts_sticky` becomes 1 on the clock edge after the one where `cts_status` goes from 0 to 1. It stays 1 until it is cleared.
- R4: A cycle with `stat_wr` = 1 and `wr_data[12]` = 1 clears `cts_sticky` on that edge. A `stat_wr` with `wr_data[12]` = 0 leaves it unchanged.
- R5: When a rising edge would set `cts_sticky` in the same cycle as a clearing write, the flag ends up set.
- R6: `line_irq` is 1 exactly when `cts_sticky` is 1 and `sticky_irq_en` is 1.
- R7: With `auto_cts_en` = 1, an edge with `char_boundary` = 1 loads `tx_permit` with the `cts_status` value of that cycle. The pause bit has no effect in this mode.
- R8: With `auto_cts_en` = 0, an edge with `char_boundary` = 1 loads `tx_permit` with the inverse of the pause bit, whatever `cts_status` is. The pause bit is loaded from `wr_data[0]` on an edge with `ctl_wr` = 1.
- R9: On an edge with `char_boundary` = 0, `tx_permit` holds its value.
- R10: Reset (active-low `rst_n`) clears `cts_status`, `cts_sticky`, `tx_permit` and the pause bit, and `line_irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_pin | input | 1 | Asynchronous clear-to-send pin |
| cts_pol_hi | input | 1 | 1: pin high means ready; 0: pin low means ready |
| auto_cts_en | input | 1 | Automatic handshaking enable |
| loopback_en | input | 1 | Take status from `rts_manual` instead of the pin |
| rts_manual | input | 1 | Manual request-to-send control bit |
| sticky_irq_en | input | 1 | Interrupt enable for the sticky flag |
| ctl_wr | input | 1 | Control write strobe (pause bit from `wr_data[0]`) |
| stat_wr | input | 1 | Status write strobe (write 1 to `wr_data[12]` clears sticky) |
| wr_data | input | DATA_W | Register write data |
| char_boundary | input | 1 | Transmitter is between characters |
| tx_permit | output | 1 | Serializer may start the next character |
| cts_status | output | 1 | Live clear-to-send status |
| cts_sticky | output | 1 | Sticky rising-edge flag |
| line_irq | output | 1 | Line-status interrupt request |

## Verification
Several behaviours are checked by assertions on every cycle: the sticky flag sets after each status rise, even against a clearing write; it is held or cleared according to the write strobe; the permit is frozen between character boundaries; it follows the status at boundaries in automatic mode; and loopback tracks the manual bit. The bench scenarios cover what the properties cannot see from the ports: the exact synchronizer latency and polarity inversion, the fact that the pin is ignored in loopback, the pause bit and how it is ignored under automatic handshaking, the interrupt gating, and the reset values.

// File: rtl/cts_pkg.sv
package cts_pkg;

    typedef struct packed {
        logic stat;
        logic prev;
    } sense_t;

    typedef struct packed {
        logic flag;
    } sticky_t;

    typedef struct packed {
        logic pause;
        logic permit;
    } gate_t;

endpackage

// File: rtl/cts_sync.sv
module cts_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = async_in;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], async_in};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/cts_sense.sv
module cts_sense
    import cts_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_sync,
    input  logic pol_hi,
    input  logic loop_en,
    input  logic rts_bit,
    output logic status,
    output logic rise
);
    sense_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (loop_en) s_d.stat = rts_bit;
        else         s_d.stat = pol_hi ? pin_sync : ~pin_sync;
        s_d.prev = s_q.stat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign status = s_q.stat;
    assign rise   = s_q.stat & ~s_q.prev;
endmodule

// File: rtl/cts_sticky.sv
module cts_sticky
    import cts_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    input  logic clr_req,
    input  logic irq_en,
    output logic flag,
    output logic irq
);
    sticky_t k_d, k_q;

    always_comb begin
        k_d = k_q;
        if (clr_req) k_d.flag = 1'b0;
        if (rise)    k_d.flag = 1'b1;   // hardware set beats software clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) k_q <= '0;
        else        k_q <= k_d;
    end

    assign flag = k_q.flag;
    assign irq  = k_q.flag & irq_en;
endmodule

// File: rtl/cts_txgate.sv
module cts_txgate
    import cts_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic auto_en,
    input  logic status,
    input  logic pause_wr,
    input  logic pause_val,
    input  logic boundary,
    output logic permit
);
    gate_t g_d, g_q;
    logic  allow;

    always_comb begin
        g_d   = g_q;
        allow = auto_en ? status : ~g_q.pause;
        if (pause_wr) g_d.pause  = pause_val;
        if (boundary) g_d.permit = allow;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign permit = g_q.permit;
endmodule

// File: rtl/cts_flow_ctl.sv
module cts_flow_ctl #(
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2,
    parameter int STICKY_POS  = 12,
    parameter int PAUSE_POS   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cts_pin,
    input  logic              cts_pol_hi,
    input  logic              auto_cts_en,
    input  logic              loopback_en,
    input  logic              rts_manual,
    input  logic              sticky_irq_en,
    input  logic              ctl_wr,
    input  logic              stat_wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              char_boundary,
    output logic              tx_permit,
    output logic              cts_status,
    output logic              cts_sticky,
    output logic              line_irq
);
    logic pin_sync;
    logic rise;
    logic clr_req;
    logic unused_wdata;

    assign clr_req      = stat_wr & wr_data[STICKY_POS];
    assign unused_wdata = ^wr_data;

    cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (cts_pin),
        .sync_out (pin_sync)
    );

    cts_sense u_sense (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_sync (pin_sync),
        .pol_hi   (cts_pol_hi),
        .loop_en  (loopback_en),
        .rts_bit  (rts_manual),
        .status   (cts_status),
        .rise     (rise)
    );

    cts_sticky u_sticky (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise    (rise),
        .clr_req (clr_req),
        .irq_en  (sticky_irq_en),
        .flag    (cts_sticky),
        .irq     (line_irq)
    );

    cts_txgate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .auto_en   (auto_cts_en),
        .status    (cts_status),
        .pause_wr  (ctl_wr),
        .pause_val (wr_data[PAUSE_POS]),
        .boundary  (char_boundary),
        .permit    (tx_permit)
    );
endmodule

// File: rtl/cts_flow_ctl_chk.sv
module cts_flow_ctl_chk #(
    parameter int DATA_W     = 32,
    parameter int STICKY_POS = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              auto_cts_en,
    input logic              loopback_en,
    input logic              rts_manual,
    input logic              sticky_irq_en,
    input logic              stat_wr,
    input logic [DATA_W-1:0] wr_data,
    input logic              char_boundary,
    input logic              tx_permit,
    input logic              cts_status,
    input logic              cts_sticky,
    input logic              line_irq
);
    assert_sticky_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cts_status) |=> cts_sticky);

    assert_sticky_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cts_sticky && !(stat_wr && wr_data[STICKY_POS])) |=> cts_sticky);

    assert_sticky_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && wr_data[STICKY_POS] && !$rose(cts_status)) |=> !cts_sticky);

    assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sticky_irq_en |-> !line_irq);

    assert_permit_follows_cts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (char_boundary && auto_cts_en) |=> (tx_permit == $past(cts_status)));

    assert_permit_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !char_boundary |=> $stable(tx_permit));

    assert_loop_tracks_rts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        loopback_en |=> (cts_status == $past(rts_manual)));
endmodule

bind cts_flow_ctl cts_flow_ctl_chk #(.DATA_W(DATA_W), .STICKY_POS(STICKY_POS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .auto_cts_en   (auto_cts_en),
    .loopback_en   (loopback_en),
    .rts_manual    (rts_manual),
    .sticky_irq_en (sticky_irq_en),
    .stat_wr       (stat_wr),
    .wr_data       (wr_data),
    .char_boundary (char_boundary),
    .tx_permit     (tx_permit),
    .cts_status    (cts_status),
    .cts_sticky    (cts_sticky),
    .line_irq      (line_irq)
);

// File: tb/cts_flow_ctl_bench.sv
`timescale 1ns/1ps
module cts_flow_ctl_bench;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cts_pin = 1'b0, cts_pol_hi = 1'b1, auto_cts_en = 1'b0;
    logic loopback_en = 1'b0, rts_manual = 1'b0, sticky_irq_en = 1'b0;
    logic ctl_wr = 1'b0, stat_wr = 1'b0, char_boundary = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic tx_permit, cts_status, cts_sticky, line_irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    cts_flow_ctl u_cts_flow_ctl (
        .clk(clk), .rst_n(rst_n), .cts_pin(cts_pin), .cts_pol_hi(cts_pol_hi),
        .auto_cts_en(auto_cts_en), .loopback_en(loopback_en), .rts_manual(rts_manual),
        .sticky_irq_en(sticky_irq_en), .ctl_wr(ctl_wr), .stat_wr(stat_wr),
        .wr_data(wr_data), .char_boundary(char_boundary), .tx_permit(tx_permit),
        .cts_status(cts_status), .cts_sticky(cts_sticky), .line_irq(line_irq)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_sticky();
        stat_wr = 1'b1; wr_data = 32'h1 << 12;
        step(1);
        stat_wr = 1'b0; wr_data = '0;
    endtask

    task automatic t_reset();
        step(4);
        chk("R10 status in reset", cts_status, 1'b0);
        chk("R10 sticky in reset", cts_sticky, 1'b0);
        chk("R10 permit in reset", tx_permit, 1'b0);
        chk("R10 irq in reset", line_irq, 1'b0);
        rst_n = 1'b1;
        char_boundary = 1'b1;
        step(1);
        chk("R10 pause cleared -> permit", tx_permit, 1'b1);
        char_boundary = 1'b0;
    endtask

    task automatic t_polarity();
        cts_pin = 1'b1;
        step(2);
        chk("R1 status before sync latency", cts_status, 1'b0);
        step(1);
        chk("R1 status after 3 edges", cts_status, 1'b1);
        chk("R3 sticky not yet set", cts_sticky, 1'b0);
        step(1);
        chk("R3 sticky set one edge later", cts_sticky, 1'b1);
        cts_pol_hi = 1'b0;
        step(1);
        chk("R1 inverted polarity", cts_status, 1'b0);
        cts_pol_hi = 1'b1;
        step(1);
        chk("R1 normal polarity", cts_status, 1'b1);
    endtask

    task automatic t_irq();
        sticky_irq_en = 1'b0; #1;
        chk("R6 irq masked", line_irq, 1'b0);
        sticky_irq_en = 1'b1; #1;
        chk("R6 irq enabled", line_irq, 1'b1);
        sticky_irq_en = 1'b0; #1;
        chk("R6 irq masked again", line_irq, 1'b0);
    endtask

    task automatic t_w1c();
        stat_wr = 1'b1; wr_data = 32'hFFFF_EFFF;
        step(1);
        stat_wr = 1'b0; wr_data = '0;
        chk("R4 write of 0 keeps sticky", cts_sticky, 1'b1);
        clear_sticky();
        chk("R4 write 1 clears sticky", cts_sticky, 1'b0);
    endtask

    task automatic t_loop();
        loopback_en = 1'b1; rts_manual = 1'b0;
        step(1);
        chk("R2 status from rts low", cts_status, 1'b0);
        cts_pin = 1'b0;
        step(3);
        chk("R2 pin ignored in loopback", cts_status, 1'b0);
        rts_manual = 1'b1;
        step(1);
        chk("R2 status from rts high", cts_status, 1'b1);
        rts_manual = 1'b0;
        step(1);
        chk("R3 loop rise sets sticky", cts_sticky, 1'b1);
        clear_sticky();
        chk("R4 cleared after loop", cts_sticky, 1'b0);
    endtask

    task automatic t_setwins();
        rts_manual = 1'b1;
        step(1);
        chk("R5 status up", cts_status, 1'b1);
        clear_sticky();
        chk("R5 set beats clear", cts_sticky, 1'b1);
        clear_sticky();
        chk("R5 later clear works", cts_sticky, 1'b0);
    endtask

    task automatic t_auto();
        auto_cts_en = 1'b1; char_boundary = 1'b1;
        step(1);
        chk("R7 permit follows ready", tx_permit, 1'b1);
        rts_manual = 1'b0;
        step(2);
        chk("R7 permit follows busy", tx_permit, 1'b0);
        ctl_wr = 1'b1; wr_data = 32'h1;
        step(1);
        ctl_wr = 1'b0; wr_data = '0;
        rts_manual = 1'b1;
        step(2);
        chk("R7 pause ignored in auto", tx_permit, 1'b1);
    endtask

    task automatic t_hold();
        char_boundary = 1'b0; rts_manual = 1'b0;
        step(3);
        chk("R9 permit held mid-frame", tx_permit, 1'b1);
        char_boundary = 1'b1;
        step(1);
        chk("R9 permit updates at boundary", tx_permit, 1'b0);
        char_boundary = 1'b0;
    endtask

    task automatic t_pause();
        auto_cts_en = 1'b0; char_boundary = 1'b1;
        step(1);
        chk("R8 paused permit low", tx_permit, 1'b0);
        ctl_wr = 1'b1; wr_data = '0;
        step(1);
        ctl_wr = 1'b0;
        step(1);
        chk("R8 unpaused, cts busy ignored", tx_permit, 1'b1);
        char_boundary = 1'b0;
    endtask

    initial begin : watchdog
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_polarity();
        t_irq();
        t_w1c();
        t_loop();
        t_setwins();
        t_auto();
        t_hold();
        t_pause();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule